// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block protects an 8-bit memory word with a 13-bit positional Hamming codeword. On the write side it turns a data byte into the codeword to be stored. On the read side it takes a stored codeword, which may be damaged. It returns the repaired data byte, the syndrome and two flags. One flag means a single bit was corrected. The other means the word holds more damage than can be repaired.

Both paths are combinational. They feed one output register, which is loaded when `in_valid` is high. The results therefore appear one clock after the request, together with `out_valid`. The write-side and read-side inputs share the same request strobe. A memory controller uses the encoded word when it writes and the decoded results when it reads.

Inside the codeword, each check bit sits at a power-of-two position. The syndrome, read as a binary number, names the position of a single bad bit. A final whole-word parity bit tells an odd number of flips apart from an even number.

Top module: `secded13_codec`

## Requirements
- R1: Codeword bit index i holds position i+1. The data byte fills positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order, starting from data bit 7. Positions 1, 2, 4 and 8 hold check bits.
- R2: The check bit at position 2^s makes the parity even over every position from 1 to 12 whose number has bit s set. For example, data 0xC4 encodes to `out_code` 13'h129C.
- R3: Position 13 (bit 12) is the XOR of positions 1 to 12, so every encoded word has even parity over all 13 bits.
- R4: The syndrome is the XOR of the numbers of all positions 1 to 12 that hold a 1, with bit 0 standing for weight 1. An undamaged word gives syndrome 0, no flag, and its own data.
- R5: A word with odd total parity and a syndrome from 1 to 12 has the bit at that position inverted. The single flag is raised, and the data comes from the repaired word. A flip of position 1 gives syndrome 1, and a flip of position 5 gives syndrome 5.
- R6: A word with odd total parity and syndrome 0 raises the single flag. The data passes through unchanged.
- R7: A word with even total parity and a nonzero syndrome raises the double flag. The data is taken from the received word with no bit inverted.
- R8: A word with odd total parity and a syndrome of 13 to 15 raises the double flag. The data is not altered.
- R9: `out_valid` equals `in_valid` of the previous clock. All results belong to the request of that clock.
- R10: A synchronous reset clears `out_valid`, `out_single` and `out_double`.
- R11: `out_single` and `out_double` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; loads the output register |
| wr_data | input | 8 | Data byte to encode |
| rd_word | input | 13 | Stored codeword to decode, bit i = position i+1 |
| out_valid | output | 1 | Results below belong to the previous request |
| out_code | output | 13 | Encoded codeword of `wr_data` |
| out_data | output | 8 | Repaired data byte of `rd_word` |
| out_syndrome | output | 4 | Syndrome of `rd_word` |
| out_single | output | 1 | Single error found (and repaired if it was in positions 1 to 12) |
| out_double | output | 1 | Uncorrectable error found; data not altered |

## Verification
The assertions assume that reset is held for at least one clock before any request, and that `in_valid` is a clean level sampled only at rising edges. The parity and flag properties look back one cycle to `rd_word`, so they need the inputs to stay stable from the falling edge to the next rising edge. The bench changes every input only on falling edges and starts with reset held. It also applies reset again mid-run only between requests, so each output it checks comes from exactly one request.

// File: rtl/secded13_codec.sv
module secded13_codec #(
  parameter int DW = 8,
  parameter int SW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DW-1:0]       wr_data,
  input  logic [DW+SW:0]      rd_word,
  output logic                out_valid,
  output logic [DW+SW:0]      out_code,
  output logic [DW-1:0]       out_data,
  output logic [SW-1:0]       out_syndrome,
  output logic                out_single,
  output logic                out_double
);
  localparam int NPOS = DW + SW;
  localparam int CW   = NPOS + 1;

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic int data_pos(input int j);
    int seen;
    seen = 0;
    for (int p = 1; p <= NPOS; p++)
      if (!is_pow2(p)) begin
        if (seen == j) return p;
        seen++;
      end
    return 1;
  endfunction

  function automatic logic [NPOS-1:0] grp_mask(input int s);
    logic [NPOS-1:0] m;
    for (int p = 1; p <= NPOS; p++) m[p-1] = ((p >> s) & 1) == 1;
    return m;
  endfunction

  logic [NPOS-1:0] dat_body, enc_body, flip, fixed;
  logic [SW-1:0]   syn;
  logic            ptot, is_single, is_double;
  logic [DW-1:0]   dec_data;
  logic [CW-1:0]   enc_word;

  for (genvar j = 0; j < DW; j++) begin : g_place
    assign dat_body[data_pos(j)-1] = wr_data[DW-1-j];
    assign dec_data[DW-1-j]        = fixed[data_pos(j)-1];
  end

  for (genvar s = 0; s < SW; s++) begin : g_chk
    assign dat_body[(1<<s)-1] = 1'b0;
    assign enc_body[(1<<s)-1] = ^(dat_body & grp_mask(s));
    assign syn[s]             = ^(rd_word[NPOS-1:0] & grp_mask(s));
  end

  for (genvar p = 1; p <= NPOS; p++) begin : g_pos
    if (!is_pow2(p)) begin : g_d
      assign enc_body[p-1] = dat_body[p-1];
    end
    assign flip[p-1] = is_single && (syn == SW'(p));
  end

  assign enc_word  = {^enc_body, enc_body};
  assign ptot      = ^rd_word;
  assign is_single = ptot && (int'(syn) <= NPOS);
  assign is_double = (syn != '0) && !is_single;
  assign fixed     = rd_word[NPOS-1:0] ^ flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_single   <= 1'b0;
      out_double   <= 1'b0;
      out_code     <= '0;
      out_data     <= '0;
      out_syndrome <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code     <= enc_word;
        out_data     <= dec_data;
        out_syndrome <= syn;
        out_single   <= is_single;
        out_double   <= is_double;
      end
    end
  end
endmodule

module secded13_codec_chk #(
  parameter int DW = 8,
  parameter int SW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [DW+SW:0] rd_word,
  input logic           out_valid,
  input logic [DW+SW:0] out_code,
  input logic [SW-1:0]  out_syndrome,
  input logic           out_single,
  input logic           out_double
);
  localparam int NPOS = DW + SW;

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_single && out_double));
  a_r3_even_word: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^out_code) == 1'b0);
  a_r4_zero_syn_not_double: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_syndrome == '0) |-> !out_double);
  a_r6_parity_only: assert property (@(posedge clk) disable iff (rst)
    in_valid && ((^rd_word) == 1'b1) |=> out_single || out_double);
  a_r7_even_nonzero: assert property (@(posedge clk) disable iff (rst)
    in_valid && ((^rd_word) == 1'b0) |=> (out_syndrome == '0) || out_double);
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_double && int'(out_syndrome) <= NPOS) |-> !out_single);
endmodule

bind secded13_codec secded13_codec_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rd_word(rd_word),
  .out_valid(out_valid), .out_code(out_code), .out_syndrome(out_syndrome),
  .out_single(out_single), .out_double(out_double));

// File: tb/test_secded13_codec.sv
module test_secded13_codec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [12:0] rd_word = '0;
  logic        out_valid, out_single, out_double;
  logic [12:0] out_code;
  logic [7:0]  out_data;
  logic [3:0]  out_syndrome;

  int n_chk = 0;
  int n_bad = 0;

  logic        e_valid, e_single, e_double;
  logic [12:0] e_code;
  logic [7:0]  e_data;
  logic [3:0]  e_syn;
  string       e_cls;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded13_codec i_secded13_codec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wr_data(wr_data),
    .rd_word(rd_word), .out_valid(out_valid), .out_code(out_code),
    .out_data(out_data), .out_syndrome(out_syndrome),
    .out_single(out_single), .out_double(out_double));

  function automatic bit pw2(input int p);
    return p == 1 || p == 2 || p == 4 || p == 8;
  endfunction

  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic [12:0] w;
    int k;
    w = '0;
    k = 7;
    for (int p = 1; p <= 12; p++)
      if (!pw2(p)) begin w[p-1] = d[k]; k--; end
    for (int s = 0; s < 4; s++) begin
      int ones;
      ones = 0;
      for (int p = 1; p <= 12; p++)
        if (((p >> s) & 1) == 1 && !pw2(p) && w[p-1]) ones++;
      w[(1 << s) - 1] = ones % 2 == 1;
    end
    w[12] = $countones(w[11:0]) % 2 == 1;
    return w;
  endfunction

  task automatic ref_dec(input logic [12:0] w, output logic [7:0] d,
                         output logic [3:0] sy, output logic sg,
                         output logic db, output string cls);
    int acc, k;
    logic [12:0] f;
    bit odd;
    acc = 0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) acc = acc ^ p;
    odd = $countones(w) % 2 == 1;
    sy = 4'(acc);
    f = w;
    sg = 1'b0;
    db = 1'b0;
    if (acc == 0 && !odd) cls = "R4";
    else if (acc == 0 && odd) begin sg = 1'b1; cls = "R6"; end
    else if (odd && acc <= 12) begin sg = 1'b1; f[acc-1] = ~f[acc-1]; cls = "R5"; end
    else if (odd) begin db = 1'b1; cls = "R8"; end
    else begin db = 1'b1; cls = "R7"; end
    k = 7;
    for (int p = 1; p <= 12; p++)
      if (!pw2(p)) begin d[k] = f[p-1]; k--; end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    chk("R9 out_valid", 32'(out_valid), 32'(e_valid));
    chk("R11 flag pair", 32'(out_single & out_double), 32'd0);
    if (rst || !e_valid) return;
    chk("R1/R2/R3 code", 32'(out_code), 32'(e_code));
    chk("R4 syndrome", 32'(out_syndrome), 32'(e_syn));
    chk({e_cls, " data"}, 32'(out_data), 32'(e_data));
    chk({e_cls, " single"}, 32'(out_single), 32'(e_single));
    chk({e_cls, " double"}, 32'(out_double), 32'(e_double));
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic [12:0] w);
    in_valid = v;
    wr_data  = d;
    rd_word  = w;
    e_valid  = v;
    if (v) begin
      e_code = ref_enc(d);
      ref_dec(w, e_data, e_syn, e_single, e_double, e_cls);
    end
    @(posedge clk);
    @(negedge clk);
    compare_now();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    e_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid", 32'(out_valid), 32'd0);
    chk("R10 single", 32'(out_single), 32'd0);
    chk("R10 double", 32'(out_double), 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] g;
    @(negedge clk);
    do_reset();

    step(1'b1, 8'hC4, 13'h129C);
    chk("R2 worked example", 32'(out_code), 32'h129C);
    step(1'b1, 8'h00, 13'h129C ^ 13'h0001);
    chk("R5 flip pos1 syndrome", 32'(out_syndrome), 32'd1);
    step(1'b1, 8'h00, 13'h129C ^ 13'h0010);
    chk("R5 flip pos5 syndrome", 32'(out_syndrome), 32'd5);
    chk("R5 flip pos5 data", 32'(out_data), 32'hC4);

    for (int d = 0; d < 256; d++) step(1'b1, 8'(d), ref_enc(8'(d)));

    for (int d = 0; d < 256; d += 17) begin
      g = ref_enc(8'(d));
      for (int p = 0; p < 13; p++) step(1'b1, 8'(d), g ^ (13'd1 << p));
      for (int p = 0; p < 12; p++) step(1'b1, 8'(d), g ^ (13'd1 << p) ^ (13'd1 << (p + 1)));
      step(1'b1, 8'(d), g ^ 13'b0_0000_1000_1001);
      step(1'b1, 8'(d), g ^ 13'b0_0000_1000_1010);
      step(1'b1, 8'(d), g ^ 13'b0_0000_1000_1100);
      step(1'b0, 8'(d), g);
    end

    do_reset();
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 3) != 0), 8'($urandom), 13'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule